// File: doc/BRIEF.md
# Buck Converter Startup and Protection Sequencer

This block is the control state machine of a single-phase synchronous buck controller. It reads a handful of comparator results (supply above power-on level, enable, switch-node level against the input-detect threshold, switch node near ground, feedback over- and under-voltage, over-temperature). From them it drives the gate overrides, the soft-start reference code, the run enable for the PWM core, the output-discharge path and the open-drain power-good release. The analog thresholds and the on-time/off-time PWM timing sit outside. All timing is counted in clock cycles and is set by parameters.

After power-on and enable, the sequencer probes the input rail. It fires short high-side pulses with the low side held off, and waits until the switch node stays quiet for several consecutive probe periods. It then strobes the overcurrent threshold sample. Next it ramps a soft-start code while the PWM core runs, and enters normal operation. Power-good is released only after a blanking interval in normal operation.

Faults must persist for a qualification window before they act. An under-voltage fault makes the sequencer stop and retry after a hiccup interval. Over-voltage and over-temperature latch until power or enable is cycled. Losing power or enable at any active point starts a discharge phase, which ends when the switch node is near ground.

Top module: `buck_seq`

## Requirements
- R1: After reset, and while `vcc_ok` and `en` are not both high in the idle state, every output is low (`ss_code` is 0). The sequencer leaves idle in the cycle after both are seen high.
- R2: During input detection, `det_req` is high and `lg_on` is low. `ug_on` is high for PROBE_WIDTH cycles at the start of every PROBE_PERIOD-cycle period, and the first period begins in the first detection cycle.
- R3: Detection completes at the end of the (QUIET_N+1)-th consecutive probe period in which `ph_hi` stayed low for every cycle after the pulse. Any `ph_hi` in that window restarts the count.
- R4: After detection, `ocset_stb` is high for exactly OCS_CYC cycles, and soft-start follows.
- R5: In soft-start, `run_en` is high. `ss_code` starts at 0 and rises by one every SS_DIV cycles up to its all-ones value. Soft-start ends SS_DIV cycles after the all-ones value is reached, so it lasts 2^SS_W * SS_DIV cycles. In normal operation `ss_code` holds at all-ones.
- R6: `pg_rel` goes high BLANK_CYC cycles after normal operation begins. It stays low in any cycle in which `fb_ov` or `fb_uv` is high.
- R7: A fault input acts only after it has been high for QUAL_CYC consecutive cycles while its check is armed. A shorter pulse has no effect.
- R8: Under-voltage is checked only in normal operation. When it trips, all gates and `run_en` go low for HICCUP_CYC cycles, and then detection restarts.
- R9: Over-voltage is checked in soft-start and in normal operation. When it trips, `lg_on` is high and `ug_on` and `run_en` are low, and this holds after `fb_ov` clears until `vcc_ok` or `en` drops.
- R10: Over-temperature is checked in detection, threshold sampling, soft-start, normal operation and hiccup. When it trips, all gates and `run_en` stay low, and this holds after `ot_hot` clears until `vcc_ok` or `en` drops.
- R11: When `vcc_ok` or `en` is low in any state other than idle and discharge, the next state is discharge. In discharge, `dis_en` is high and `lg_on` pulses with the probe timing. Discharge ends in the cycle after `ph_low` is seen high, returning to idle.
- R12: `ug_on` and `lg_on` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok | input | 1 | Supply above power-on level |
| en | input | 1 | Enable request |
| ph_hi | input | 1 | Switch node above input-detect threshold |
| ph_low | input | 1 | Switch node below discharge-done level |
| fb_ov | input | 1 | Feedback above over-voltage threshold |
| fb_uv | input | 1 | Feedback below under-voltage threshold |
| ot_hot | input | 1 | Die over-temperature |
| ug_on | output | 1 | Force high-side gate on |
| lg_on | output | 1 | Force low-side gate on |
| det_req | output | 1 | Input-detection phase active |
| ocset_stb | output | 1 | Overcurrent threshold sample strobe |
| ss_code | output | SS_W | Soft-start reference code |
| run_en | output | 1 | PWM core enabled |
| dis_en | output | 1 | Feedback-to-ground discharge path on |
| pg_rel | output | 1 | Release power-good (open drain high-Z) |

## Verification
The first startup has a noisy switch node in the first probe period. This separates a detector that counts every quiet period from one that restarts on noise, and the measured detection length must equal five periods. A fault pulse shorter than the qualification window is applied during normal operation, alongside a held one. This distinguishes debounced trips from raw ones, and a one-cycle over-voltage shows that power-good drops at once without a trip. Under-voltage is held through a whole restart, which shows it is ignored in soft-start. The over-voltage and over-temperature latches are released through different paths (enable, then supply), which exercises discharge and both routes back to idle.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
   typedef enum logic [3:0] {
      S_OFF, S_DETECT, S_OCPROG, S_SOFT, S_RUN,
      S_HICCUP, S_LAT_OV, S_LAT_OT, S_DISCH
   } seq_state_t;

   localparam int FLT_OV = 0;
   localparam int FLT_UV = 1;
   localparam int FLT_OT = 2;
   localparam int FLT_N  = 3;
endpackage

// File: rtl/buck_seq_probe.sv
module buck_seq_probe #(
   parameter int PERIOD = 8,
   parameter int WIDTH  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic pulse,
   output logic off_win,
   output logic wrap
);
   localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
   localparam logic [CW-1:0] WLIM = CW'(WIDTH);

   generate
      if (WIDTH < 1 || WIDTH >= PERIOD) begin : g_bad_width
         $error("probe WIDTH must be between 1 and PERIOD-1");
      end
   endgenerate

   logic [CW-1:0] pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pc <= '0;
      else if (!active)     pc <= '0;
      else if (pc == LAST)  pc <= '0;
      else                  pc <= pc + 1'b1;
   end

   assign pulse   = active && (pc < WLIM);
   assign off_win = active && (pc >= WLIM);
   assign wrap    = active && (pc == LAST);

   AST_PULSE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> pulse); // R2
   AST_PULSE_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && !$past(pulse) && $past(active)) |-> $past(wrap)); // R2
endmodule

// File: rtl/buck_seq_qual.sv
module buck_seq_qual #(
   parameter int QUAL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic cond,
   output logic trip
);
   generate
      if (QUAL < 0) begin : g_bad_qual
         $error("QUAL must not be negative");
      end
      if (QUAL == 0) begin : g_direct
         assign trip = armed && cond;
      end else begin : g_count
         localparam int QW = $clog2(QUAL + 1);
         localparam logic [QW-1:0] QTOP = QW'(QUAL);
         logic [QW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt <= '0;
            else if (armed && cond) begin
               if (cnt != QTOP)      cnt <= cnt + 1'b1;
            end else                 cnt <= '0;
         end

         assign trip = armed && (cnt == QTOP);

         AST_TRIP_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            trip |-> ($past(cond) && $past(armed))); // R7
      end
   endgenerate
endmodule

// File: rtl/buck_seq_ramp.sv
module buck_seq_ramp #(
   parameter int SS_W   = 4,
   parameter int SS_DIV = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ramp,
   input  logic            hold,
   output logic [SS_W-1:0] code,
   output logic            done
);
   localparam logic [SS_W-1:0] CMAX = '1;
   logic step;

   generate
      if (SS_W < 1 || SS_DIV < 1) begin : g_bad_ramp
         $error("SS_W and SS_DIV must be at least 1");
      end
      if (SS_DIV == 1) begin : g_nodiv
         assign step = ramp;
      end else begin : g_div
         localparam int DW = $clog2(SS_DIV);
         localparam logic [DW-1:0] DLAST = DW'(SS_DIV - 1);
         logic [DW-1:0] div;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          div <= '0;
            else if (ramp)       div <= (div == DLAST) ? '0 : div + 1'b1;
            else if (!hold)      div <= '0;
         end
         assign step = ramp && (div == DLAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          code <= '0;
      else if (ramp) begin
         if (step && code != CMAX)         code <= code + 1'b1;
      end else if (!hold)                  code <= '0;
   end

   assign done = step && (code == CMAX);

   AST_RAMP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp && $past(ramp)) |-> (code >= $past(code))); // R5
endmodule

// File: rtl/buck_seq.sv
module buck_seq
   import buck_seq_pkg::*;
#(
   parameter int PROBE_PERIOD = 8,
   parameter int PROBE_WIDTH  = 2,
   parameter int QUIET_N      = 3,
   parameter int OCS_CYC      = 3,
   parameter int SS_W         = 4,
   parameter int SS_DIV       = 2,
   parameter int BLANK_CYC    = 20,
   parameter int QUAL_CYC     = 4,
   parameter int HICCUP_CYC   = 30
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vcc_ok,
   input  logic            en,
   input  logic            ph_hi,
   input  logic            ph_low,
   input  logic            fb_ov,
   input  logic            fb_uv,
   input  logic            ot_hot,
   output logic            ug_on,
   output logic            lg_on,
   output logic            det_req,
   output logic            ocset_stb,
   output logic [SS_W-1:0] ss_code,
   output logic            run_en,
   output logic            dis_en,
   output logic            pg_rel
);
   localparam int TMAX0 = (BLANK_CYC > HICCUP_CYC) ? BLANK_CYC : HICCUP_CYC;
   localparam int TMAX  = (TMAX0 > OCS_CYC) ? TMAX0 : OCS_CYC;
   localparam int TW    = $clog2(TMAX + 1);
   localparam int QCW   = (QUIET_N > 0) ? $clog2(QUIET_N + 1) : 1;
   localparam logic [TW-1:0]  T_BLANK = TW'(BLANK_CYC);
   localparam logic [TW-1:0]  T_OCS   = TW'(OCS_CYC - 1);
   localparam logic [TW-1:0]  T_HIC   = TW'(HICCUP_CYC - 1);
   localparam logic [QCW-1:0] Q_TOP   = QCW'(QUIET_N);

   generate
      if (OCS_CYC < 1 || BLANK_CYC < 1 || HICCUP_CYC < 1 || QUIET_N < 0) begin : g_bad_cfg
         $error("sequencer timing parameters out of range");
      end
   endgenerate

   seq_state_t state, nstate;
   logic [TW-1:0]  tmr;
   logic [QCW-1:0] qc;
   logic           seen;

   // probe pulse generator shared by detection and discharge
   logic pr_active, pr_pulse, pr_off, pr_wrap;
   assign pr_active = (state == S_DETECT) || (state == S_DISCH);

   buck_seq_probe #(.PERIOD(PROBE_PERIOD), .WIDTH(PROBE_WIDTH)) u_probe (
      .clk(clk), .rst_n(rst_n), .active(pr_active),
      .pulse(pr_pulse), .off_win(pr_off), .wrap(pr_wrap));

   // soft-start ramp
   logic ss_done;
   buck_seq_ramp #(.SS_W(SS_W), .SS_DIV(SS_DIV)) u_ramp (
      .clk(clk), .rst_n(rst_n), .ramp(state == S_SOFT), .hold(state == S_RUN),
      .code(ss_code), .done(ss_done));

   // fault qualifiers
   logic [FLT_N-1:0] f_arm, f_cond, f_trip;
   assign f_cond[FLT_OV] = fb_ov;
   assign f_cond[FLT_UV] = fb_uv;
   assign f_cond[FLT_OT] = ot_hot;
   assign f_arm[FLT_OV]  = (state == S_SOFT) || (state == S_RUN);
   assign f_arm[FLT_UV]  = (state == S_RUN);
   assign f_arm[FLT_OT]  = (state == S_DETECT) || (state == S_OCPROG) || (state == S_SOFT) ||
                           (state == S_RUN) || (state == S_HICCUP);

   genvar gi;
   generate
      for (gi = 0; gi < FLT_N; gi++) begin : g_qual
         buck_seq_qual #(.QUAL(QUAL_CYC)) u_q (
            .clk(clk), .rst_n(rst_n), .armed(f_arm[gi]), .cond(f_cond[gi]),
            .trip(f_trip[gi]));
      end
   endgenerate

   logic pwr_drop, clean_end;
   assign pwr_drop  = !vcc_ok || !en;
   assign clean_end = pr_wrap && !seen && !ph_hi;

   always_comb begin
      nstate = state;
      unique case (state)
         S_OFF:      if (!pwr_drop) nstate = S_DETECT;
         S_DETECT: begin
            if (pwr_drop)                    nstate = S_DISCH;
            else if (f_trip[FLT_OT])         nstate = S_LAT_OT;
            else if (clean_end && qc == Q_TOP) nstate = S_OCPROG;
         end
         S_OCPROG: begin
            if (pwr_drop)                    nstate = S_DISCH;
            else if (f_trip[FLT_OT])         nstate = S_LAT_OT;
            else if (tmr == T_OCS)           nstate = S_SOFT;
         end
         S_SOFT: begin
            if (pwr_drop)                    nstate = S_DISCH;
            else if (f_trip[FLT_OT])         nstate = S_LAT_OT;
            else if (f_trip[FLT_OV])         nstate = S_LAT_OV;
            else if (ss_done)                nstate = S_RUN;
         end
         S_RUN: begin
            if (pwr_drop)                    nstate = S_DISCH;
            else if (f_trip[FLT_OT])         nstate = S_LAT_OT;
            else if (f_trip[FLT_OV])         nstate = S_LAT_OV;
            else if (f_trip[FLT_UV])         nstate = S_HICCUP;
         end
         S_HICCUP: begin
            if (pwr_drop)                    nstate = S_DISCH;
            else if (f_trip[FLT_OT])         nstate = S_LAT_OT;
            else if (tmr == T_HIC)           nstate = S_DETECT;
         end
         S_LAT_OV, S_LAT_OT: if (pwr_drop) nstate = S_DISCH;
         S_DISCH:    if (ph_low) nstate = S_OFF;
         default:    nstate = S_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_OFF;
         tmr   <= '0;
         qc    <= '0;
         seen  <= 1'b0;
      end else begin
         state <= nstate;
         if (nstate != state)                                tmr <= '0;
         else if (state == S_RUN)                            tmr <= (tmr == T_BLANK) ? tmr : tmr + 1'b1;
         else if (state == S_OCPROG || state == S_HICCUP)    tmr <= tmr + 1'b1;
         else                                                tmr <= '0;

         if (state != S_DETECT) begin
            qc   <= '0;
            seen <= 1'b0;
         end else if (pr_wrap) begin
            seen <= 1'b0;
            if (!clean_end)        qc <= '0;
            else if (qc != Q_TOP)  qc <= qc + 1'b1;
         end else if (pr_off && ph_hi) begin
            seen <= 1'b1;
         end
      end
   end

   assign ug_on     = (state == S_DETECT) && pr_pulse;
   assign lg_on     = (state == S_LAT_OV) || ((state == S_DISCH) && pr_pulse);
   assign det_req   = (state == S_DETECT);
   assign ocset_stb = (state == S_OCPROG);
   assign run_en    = (state == S_SOFT) || (state == S_RUN);
   assign dis_en    = (state == S_DISCH);
   assign pg_rel    = (state == S_RUN) && (tmr == T_BLANK) && !fb_ov && !fb_uv;

   AST_NO_CROSS_CONDUCTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(ug_on && lg_on)); // R12
   AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_OFF && pwr_drop) |=> (state == S_OFF)); // R1
   AST_DETECT_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      det_req |-> !lg_on); // R2
   AST_OCSET_AFTER_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ocset_stb) |-> ($past(state) == S_DETECT)); // R4
   AST_PG_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      pg_rel |-> $past(run_en)); // R6
   AST_OV_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_LAT_OV && !pwr_drop) |=> (state == S_LAT_OV)); // R9
   AST_OT_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_LAT_OT && !pwr_drop) |=> (state == S_LAT_OT)); // R10
   AST_DROP_DISCHARGES: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_drop && state != S_OFF && state != S_DISCH) |=> dis_en); // R11
endmodule

// File: tb/sim_buck_seq.sv
`timescale 1ns/100ps
module sim_buck_seq;
   localparam int P = 8, W = 2, QN = 3, OCS = 3, SSW = 4, SSD = 2;
   localparam int BLK = 20, QL = 4, HIC = 30;
   localparam int CMAX = (1 << SSW) - 1;
   localparam int SS_LEN = (CMAX + 1) * SSD;
   localparam int M_OFF = 0, M_DET = 1, M_OCP = 2, M_SOFT = 3, M_RUN = 4,
                  M_HIC = 5, M_LOV = 6, M_LOT = 7, M_DIS = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic vcc_ok = 0, en = 0, ph_hi = 0, ph_low = 0, fb_ov = 0, fb_uv = 0, ot_hot = 0;
   logic ug_on, lg_on, det_req, ocset_stb, run_en, dis_en, pg_rel;
   logic [SSW-1:0] ss_code;

   int checks = 0, errors = 0, cyc = 0;

   always #2.5 clk = ~clk;

   buck_seq #(.PROBE_PERIOD(P), .PROBE_WIDTH(W), .QUIET_N(QN), .OCS_CYC(OCS),
              .SS_W(SSW), .SS_DIV(SSD), .BLANK_CYC(BLK), .QUAL_CYC(QL),
              .HICCUP_CYC(HIC)) u0 (
      .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .en(en), .ph_hi(ph_hi),
      .ph_low(ph_low), .fb_ov(fb_ov), .fb_uv(fb_uv), .ot_hot(ot_hot),
      .ug_on(ug_on), .lg_on(lg_on), .det_req(det_req), .ocset_stb(ocset_stb),
      .ss_code(ss_code), .run_en(run_en), .dis_en(dis_en), .pg_rel(pg_rel));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // behavioural reference model
   int ms, mtmr, mqc, mseen, mpc, mdiv, mcode;
   int mcnt [3];

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
         finish_run();
      end
      if (!rst_n) begin
         ms = M_OFF; mtmr = 0; mqc = 0; mseen = 0; mpc = 0; mdiv = 0; mcode = 0;
         foreach (mcnt[i]) mcnt[i] = 0;
      end else begin
         bit act, offw, wrp, pd, clean, step, done;
         bit arm [3];
         bit cond [3];
         bit tr [3];
         int ns;
         act  = (ms == M_DET) || (ms == M_DIS);
         offw = act && (mpc >= W);
         wrp  = act && (mpc == P - 1);
         pd   = !vcc_ok || !en;
         arm[0] = (ms == M_SOFT) || (ms == M_RUN);
         arm[1] = (ms == M_RUN);
         arm[2] = (ms == M_DET) || (ms == M_OCP) || (ms == M_SOFT) || (ms == M_RUN) || (ms == M_HIC);
         cond[0] = fb_ov; cond[1] = fb_uv; cond[2] = ot_hot;
         for (int i = 0; i < 3; i++) tr[i] = arm[i] && (mcnt[i] == QL);
         clean = wrp && !mseen && !ph_hi;
         step  = (ms == M_SOFT) && (mdiv == SSD - 1);
         done  = step && (mcode == CMAX);
         ns = ms;
         if (ms == M_OFF) begin
            if (!pd) ns = M_DET;
         end else if (ms == M_DIS) begin
            if (ph_low) ns = M_OFF;
         end else if (pd) ns = M_DIS;
         else if (ms == M_LOV || ms == M_LOT) ns = ms;
         else if (tr[2]) ns = M_LOT;
         else if ((ms == M_SOFT || ms == M_RUN) && tr[0]) ns = M_LOV;
         else if (ms == M_RUN && tr[1]) ns = M_HIC;
         else if (ms == M_DET && clean && mqc == QN) ns = M_OCP;
         else if (ms == M_OCP && mtmr == OCS - 1) ns = M_SOFT;
         else if (ms == M_SOFT && done) ns = M_RUN;
         else if (ms == M_HIC && mtmr == HIC - 1) ns = M_DET;

         if (ns != ms) mtmr = 0;
         else if (ms == M_RUN) mtmr = (mtmr == BLK) ? BLK : mtmr + 1;
         else if (ms == M_OCP || ms == M_HIC) mtmr = mtmr + 1;
         else mtmr = 0;

         if (ms != M_DET) begin mqc = 0; mseen = 0; end
         else if (wrp) begin
            mseen = 0;
            if (!clean) mqc = 0; else if (mqc != QN) mqc = mqc + 1;
         end else if (offw && ph_hi) mseen = 1;

         mpc = act ? ((mpc == P - 1) ? 0 : mpc + 1) : 0;

         if (ms == M_SOFT) begin
            mdiv = (mdiv == SSD - 1) ? 0 : mdiv + 1;
            if (step && mcode != CMAX) mcode = mcode + 1;
         end else if (ms != M_RUN) begin mdiv = 0; mcode = 0; end

         for (int i = 0; i < 3; i++)
            mcnt[i] = (arm[i] && cond[i]) ? ((mcnt[i] == QL) ? QL : mcnt[i] + 1) : 0;
         ms = ns;
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit pls;
         pls = ((ms == M_DET) || (ms == M_DIS)) && (mpc < W);
         chk(ug_on == ((ms == M_DET) && pls), "R2 ug_on", ug_on, (ms == M_DET) && pls);
         chk(lg_on == ((ms == M_LOV) || ((ms == M_DIS) && pls)), "R9/R11 lg_on", lg_on,
             (ms == M_LOV) || ((ms == M_DIS) && pls));
         chk(det_req == (ms == M_DET), "R3 det_req", det_req, ms == M_DET);
         chk(ocset_stb == (ms == M_OCP), "R4 ocset_stb", ocset_stb, ms == M_OCP);
         chk(int'(ss_code) == mcode, "R5 ss_code", ss_code, mcode);
         chk(run_en == ((ms == M_SOFT) || (ms == M_RUN)), "R8 run_en", run_en,
             (ms == M_SOFT) || (ms == M_RUN));
         chk(dis_en == (ms == M_DIS), "R11 dis_en", dis_en, ms == M_DIS);
         chk(pg_rel == ((ms == M_RUN) && (mtmr == BLK) && !fb_ov && !fb_uv), "R6 pg_rel",
             pg_rel, (ms == M_RUN) && (mtmr == BLK) && !fb_ov && !fb_uv);
         chk(!(ug_on && lg_on), "R12 overlap", ug_on && lg_on, 0);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_ocset();
      while (!ocset_stb) tick(1);
   endtask

   initial begin
      int cnt;
      tick(4);
      chk(!ug_on && !lg_on && !run_en && !dis_en && !pg_rel && ss_code == 0,
          "R1 reset outputs", run_en, 0);
      rst_n = 1'b1;
      en = 1'b1;
      tick(10);
      chk(det_req == 0, "R1 waits for vcc_ok", det_req, 0);

      // startup with switch-node noise in the first probe period
      vcc_ok = 1'b1; ph_hi = 1'b1;
      tick(1);
      chk(det_req == 1 && ug_on == 1, "R2 first probe pulse", ug_on, 1);
      cnt = 1;
      tick(4); cnt += 4; ph_hi = 1'b0;
      while (det_req) begin tick(1); if (det_req) cnt++; end
      chk(cnt == (QN + 2) * P, "R3 detection length", cnt, (QN + 2) * P);
      cnt = 0;
      while (ocset_stb) begin cnt++; tick(1); end
      chk(cnt == OCS, "R4 strobe length", cnt, OCS);
      cnt = 0;
      while (run_en && !pg_rel) begin cnt++; tick(1); end
      chk(cnt == SS_LEN + BLK, "R5 R6 ramp plus blanking", cnt, SS_LEN + BLK);
      chk(int'(ss_code) == CMAX, "R5 code holds at top", ss_code, CMAX);

      // one-cycle over-voltage: power-good drops, no trip
      fb_ov = 1'b1; tick(1);
      chk(pg_rel == 0, "R6 pg low with fb_ov", pg_rel, 0);
      fb_ov = 1'b0; tick(1);
      // short under-voltage pulse ignored
      fb_uv = 1'b1; tick(QL - 1); fb_uv = 1'b0; tick(3);
      chk(run_en == 1 && pg_rel == 1, "R7 short fault ignored", run_en, 1);

      // held under-voltage -> hiccup, held through restart
      fb_uv = 1'b1; tick(QL + 2);
      chk(run_en == 0 && !ug_on && !lg_on, "R8 hiccup gates off", run_en, 0);
      wait_ocset();
      tick(OCS + SS_LEN);
      fb_uv = 1'b0;
      chk(run_en == 1 && int'(ss_code) == CMAX, "R8 uv ignored in soft-start", ss_code, CMAX);
      tick(BLK + 2);
      chk(pg_rel == 1, "R6 pg after restart", pg_rel, 1);

      // over-voltage latch, released by enable
      fb_ov = 1'b1; tick(QL + 2);
      chk(lg_on == 1 && ug_on == 0 && run_en == 0, "R9 ov latch", lg_on, 1);
      fb_ov = 1'b0; tick(20);
      chk(lg_on == 1 && run_en == 0, "R9 ov stays latched", lg_on, 1);
      en = 1'b0; tick(1);
      chk(dis_en == 1, "R11 discharge on enable drop", dis_en, 1);
      cnt = 0;
      for (int k = 0; k < 2 * P; k++) begin if (lg_on) cnt++; tick(1); end
      chk(cnt == 2 * W, "R11 discharge pulses", cnt, 2 * W);
      ph_low = 1'b1; tick(1);
      chk(dis_en == 0, "R11 discharge ends", dis_en, 0);
      tick(3); ph_low = 1'b0;

      // over-temperature latch, released by supply
      en = 1'b1;
      wait_ocset();
      tick(OCS + SS_LEN + 5);
      ot_hot = 1'b1; tick(QL + 2);
      chk(run_en == 0 && lg_on == 0 && ug_on == 0, "R10 ot shutdown", run_en, 0);
      ot_hot = 1'b0; tick(20);
      chk(run_en == 0 && det_req == 0, "R10 ot stays latched", run_en, 0);
      vcc_ok = 1'b0; tick(1);
      chk(dis_en == 1, "R11 discharge on supply drop", dis_en, 1);
      tick(5); ph_low = 1'b1; tick(2);
      chk(dis_en == 0 && det_req == 0, "R1 idle after discharge", dis_en, 0);
      tick(5);
      finish_run();
   end
endmodule